// File: doc/BRIEF.md
# Crossbar Slave Port Ownership Arbiter

This block is the control core of one slave port in a multi-master crossbar. Each cycle it decides which master will own the slave in the next cycle. When no master asks for the slave, the port stays parked on its last owner. Its result drives the select of the address/control multiplexer in front of the slave. It also issues two directives for that multiplexer: one that forces an IDLE transfer onto the slave bus, and one that forces the transfer type of a newly granted master to NONSEQ.

Each master carries a programmed 3-bit level. Its high-priority pin, gated by a per-master enable, is placed above that level as the most significant bit, giving a 4-bit effective priority. In fixed mode the 4-bit value always decides. In round-robin mode it decides only while some requesting master has an enabled high-priority pin raised. Otherwise the grant rotates.

Ownership moves only when the slave can accept the change. A handover requested while the slave inserts wait states is parked in a waiting state until `slv_hready` returns. A handover requested during a locked transfer or an undefined-length burst keeps the current master in a holding state. All pins are plain control and status; the block has no data stream and no valid/ready handshake.

Top module: `xbar_slave_arb`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `owner` is 0, `arb_state` is 0 (steady), and `force_idle` is 1 when `req` is all zero.
- R2: Master i has effective priority {`hi_pri[i]` & `hi_pri_en[i]`, `pri_lvl[3*i+2:3*i]`}. In fixed mode (`rr_mode`=0) the requesting master with the highest value wins, and a tie goes to the lowest index.
- R3: A `hi_pri` bit whose `hi_pri_en` bit is 0 changes neither the effective priority nor the choice of mode.
- R4: In round-robin mode (`rr_mode`=1) with no requester holding an enabled high-priority pin, the winner is the first requester found scanning upward from `owner`+1 with wrap-around. If such a requester exists, the highest effective priority wins and ties go to the first found in that same scan.
- R5: When the winner differs from `owner`, the transfer is neither locked nor in an undefined burst, and `slv_hready` is 1, the next edge sets `owner` to the winner and `arb_state` to 1 (transition). `force_nseq` is then 1 for that cycle.
- R6: When such a change arises with `slv_hready` at 0, the next edge sets `arb_state` to 2 (transition-hold) and latches the winner. `owner` is kept and `force_idle` is 1. The first edge with `slv_hready` at 1 moves to transition, with `owner` set to the latched master, even if requests changed meanwhile.
- R7: When a change is wanted while `own_lock` or `own_burst` is 1, the next edge sets `arb_state` to 3 (hold) and keeps `owner`. Once both are 0, the handover proceeds as in R5 or R6.
- R8: In any state other than transition-hold, when no change is wanted (no requests, or the winner already owns the port) the next edge sets `arb_state` to 0.
- R9: With `req` all zero, `owner` does not change (parking), and `force_idle` is 1 whenever the current owner's `req` bit is 0.
- R10: `force_idle` and `force_nseq` are never 1 together. In the transition state, a new owner whose request has dropped gets `force_idle`=1 and `force_nseq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MST | Per-master request for the slave |
| hi_pri | input | N_MST | Per-master high-priority pin |
| hi_pri_en | input | N_MST | Per-master enable for the high-priority pin |
| pri_lvl | input | N_MST*LVL_W | Programmed levels, master i at bits [LVL_W*i +: LVL_W] |
| rr_mode | input | 1 | 1 = round-robin, 0 = fixed priority |
| slv_hready | input | 1 | Slave ready, 1 = transfer boundary |
| own_lock | input | 1 | Current owner runs a locked transfer |
| own_burst | input | 1 | Current owner is inside an undefined-length burst |
| owner | output | IDW | Master that owns the slave this cycle (mux select) |
| arb_state | output | 2 | 0 steady, 1 transition, 2 transition-hold, 3 hold |
| force_idle | output | 1 | Drive an IDLE transfer onto the slave bus |
| force_nseq | output | 1 | Force the granted master's transfer type to NONSEQ |

## Verification
`owner` and `arb_state` are registered, so the bench expects them one rising edge after it applies a request pattern. `force_idle` and `force_nseq` combine that registered state with the live `req` bits, so they are due in the same cycle. Every vector is applied a quarter period after an edge and read a quarter period after the next edge. This lets both the registered and the combinational results be compared against the values computed for the pattern in force. The request-drop case in R10 is checked within a single cycle, before the following edge.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  typedef enum logic [1:0] {
    ST_STEADY = 2'd0,
    ST_TRANS  = 2'd1,
    ST_THOLD  = 2'd2,
    ST_HOLD   = 2'd3
  } arb_state_e;
endpackage

// File: rtl/xsa_prio_arb.sv
// Combinational winner selection over the request vector.
module xsa_prio_arb #(
  parameter int N_MST = 4,
  parameter int LVL_W = 3,
  localparam int IDW   = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int KEY_W = LVL_W + 1
) (
  input  logic [N_MST-1:0]       req,
  input  logic [N_MST-1:0]       hi_pri,
  input  logic [N_MST-1:0]       hi_pri_en,
  input  logic [N_MST*LVL_W-1:0] pri_lvl,
  input  logic                   rr_mode,
  input  logic [IDW-1:0]         last_own,
  output logic                   any_req,
  output logic [IDW-1:0]         win
);
  logic [KEY_W-1:0] eff [N_MST];
  logic [N_MST-1:0] hp_act;

  for (genvar g = 0; g < N_MST; g++) begin : g_eff
    assign eff[g]    = {hi_pri[g] & hi_pri_en[g], pri_lvl[g*LVL_W +: LVL_W]};
    assign hp_act[g] = hi_pri[g] & hi_pri_en[g] & req[g];
  end

  assign any_req = |req;

  always_comb begin
    logic             use_pri;
    logic             found;
    logic [KEY_W-1:0] best;
    logic [KEY_W-1:0] key;
    logic [IDW-1:0]   idx;
    use_pri = !rr_mode || (|hp_act);
    found   = 1'b0;
    best    = '0;
    win     = last_own;
    for (int k = 0; k < N_MST; k++) begin
      if (rr_mode) idx = IDW'((int'(last_own) + 1 + k) % N_MST);
      else         idx = IDW'(k);
      key = use_pri ? eff[idx] : '0;
      if (req[idx] && (!found || key > best)) begin
        found = 1'b1;
        best  = key;
        win   = idx;
      end
    end
  end
endmodule

// File: rtl/xsa_ctrl_fsm.sv
// Four-state ownership controller.
module xsa_ctrl_fsm #(
  parameter int N_MST = 4,
  localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MST-1:0]     req,
  input  logic                 any_req,
  input  logic [IDW-1:0]       win,
  input  logic                 slv_hready,
  input  logic                 own_lock,
  input  logic                 own_burst,
  output logic [IDW-1:0]       owner,
  output xbar_arb_pkg::arb_state_e state,
  output logic                 force_idle,
  output logic                 force_nseq
);
  import xbar_arb_pkg::*;

  arb_state_e     st_q, st_d;
  logic [IDW-1:0] own_q, own_d, tgt_q, tgt_d;
  logic           change, blocked;

  assign change  = any_req && (win != own_q);
  assign blocked = own_lock || own_burst;

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    tgt_d = tgt_q;
    if (st_q == ST_THOLD) begin
      if (slv_hready) begin
        st_d  = ST_TRANS;
        own_d = tgt_q;
      end
    end else if (!change) begin
      st_d = ST_STEADY;
    end else if (blocked) begin
      st_d = ST_HOLD;
    end else if (!slv_hready) begin
      st_d  = ST_THOLD;
      tgt_d = win;
    end else begin
      st_d  = ST_TRANS;
      own_d = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_STEADY;
      own_q <= '0;
      tgt_q <= '0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
      tgt_q <= tgt_d;
    end
  end

  assign owner      = own_q;
  assign state      = st_q;
  assign force_idle = (st_q == ST_THOLD) || !req[own_q];
  assign force_nseq = (st_q == ST_TRANS) && !force_idle;
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb #(
  parameter int N_MST = 4,
  parameter int LVL_W = 3,
  localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MST-1:0]       req,
  input  logic [N_MST-1:0]       hi_pri,
  input  logic [N_MST-1:0]       hi_pri_en,
  input  logic [N_MST*LVL_W-1:0] pri_lvl,
  input  logic                   rr_mode,
  input  logic                   slv_hready,
  input  logic                   own_lock,
  input  logic                   own_burst,
  output logic [IDW-1:0]         owner,
  output logic [1:0]             arb_state,
  output logic                   force_idle,
  output logic                   force_nseq
);
  import xbar_arb_pkg::*;

  logic           any_req;
  logic [IDW-1:0] win;
  arb_state_e     st;

  xsa_prio_arb #(.N_MST(N_MST), .LVL_W(LVL_W)) u_arb (
    .req(req), .hi_pri(hi_pri), .hi_pri_en(hi_pri_en), .pri_lvl(pri_lvl),
    .rr_mode(rr_mode), .last_own(owner), .any_req(any_req), .win(win)
  );

  xsa_ctrl_fsm #(.N_MST(N_MST)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .any_req(any_req), .win(win),
    .slv_hready(slv_hready), .own_lock(own_lock), .own_burst(own_burst),
    .owner(owner), .state(st), .force_idle(force_idle), .force_nseq(force_nseq)
  );

  assign arb_state = st;
endmodule

// File: rtl/xbar_slave_arb_chk.sv
module xbar_slave_arb_chk #(
  parameter int N_MST = 4,
  localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req,
  input logic             slv_hready,
  input logic [IDW-1:0]   owner,
  input logic [1:0]       arb_state,
  input logic             force_idle,
  input logic             force_nseq
);
  // R10
  idle_nseq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_idle && force_nseq));

  // R5
  trans_new_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 2'd1) |-> (owner != $past(owner)));

  // R6
  thold_keeps_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 2'd2) |-> (owner == $past(owner) && force_idle));

  // R6
  thold_waits_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 2'd2 && !slv_hready) |=> (arb_state == 2'd2));

  // R7
  hold_keeps_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 2'd3) |-> (owner == $past(owner)));

  // R9
  park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> force_idle);
endmodule

bind xbar_slave_arb xbar_slave_arb_chk #(.N_MST(N_MST)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .slv_hready(slv_hready),
  .owner(owner), .arb_state(arb_state), .force_idle(force_idle),
  .force_nseq(force_nseq)
);

// File: tb/tb_xbar_slave_arb.sv
module tb_xbar_slave_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 25;

  typedef struct packed {
    logic [3:0] rq; logic [3:0] hp; logic [3:0] en;
    logic rr; logic rdy; logic lk; logic bu;
    logic [1:0] own; logic [1:0] st; logic fi; logic fn;
  } vec_t;

  // levels: m0=2 m1=5 m2=5 m3=1
  localparam vec_t TBL [NROW] = '{
    '{4'b0001,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0}, // 0  R8
    '{4'b0110,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,1'b1}, // 1  R2 tie
    '{4'b0110,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd1,2'd0,1'b0,1'b0}, // 2  R8
    '{4'b1010,4'b1000,4'b1000,1'b0,1'b1,1'b0,1'b0,2'd3,2'd1,1'b0,1'b1}, // 3  R2 msb
    '{4'b1010,4'b1000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,1'b1}, // 4  R3
    '{4'b0000,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd1,2'd0,1'b1,1'b0}, // 5  R9
    '{4'b0001,4'b0000,4'b0000,1'b0,1'b0,1'b0,1'b0,2'd1,2'd2,1'b1,1'b0}, // 6  R6
    '{4'b0001,4'b0000,4'b0000,1'b0,1'b0,1'b0,1'b0,2'd1,2'd2,1'b1,1'b0}, // 7  R6
    '{4'b0001,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd0,2'd1,1'b0,1'b1}, // 8  R6
    '{4'b0101,4'b0000,4'b0000,1'b0,1'b1,1'b1,1'b0,2'd0,2'd3,1'b0,1'b0}, // 9  R7 lock
    '{4'b0101,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b1,2'd0,2'd3,1'b0,1'b0}, // 10 R7 burst
    '{4'b0101,4'b0000,4'b0000,1'b0,1'b0,1'b0,1'b0,2'd0,2'd2,1'b1,1'b0}, // 11 R7
    '{4'b0101,4'b0000,4'b0000,1'b0,1'b1,1'b0,1'b0,2'd2,2'd1,1'b0,1'b1}, // 12 R5
    '{4'b1001,4'b0000,4'b0000,1'b0,1'b1,1'b1,1'b0,2'd2,2'd3,1'b1,1'b0}, // 13 R7
    '{4'b0100,4'b0000,4'b0000,1'b0,1'b1,1'b1,1'b0,2'd2,2'd0,1'b0,1'b0}, // 14 R8
    '{4'b1111,4'b0000,4'b0000,1'b1,1'b1,1'b0,1'b0,2'd3,2'd1,1'b0,1'b1}, // 15 R4
    '{4'b1111,4'b0000,4'b0000,1'b1,1'b1,1'b0,1'b0,2'd0,2'd1,1'b0,1'b1}, // 16 R4 wrap
    '{4'b1111,4'b0000,4'b0000,1'b1,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,1'b1}, // 17 R4
    '{4'b0101,4'b0000,4'b0000,1'b1,1'b1,1'b0,1'b0,2'd2,2'd1,1'b0,1'b1}, // 18 R4
    '{4'b1011,4'b0001,4'b0001,1'b1,1'b1,1'b0,1'b0,2'd0,2'd1,1'b0,1'b1}, // 19 R4 hp
    '{4'b1011,4'b0011,4'b0011,1'b1,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,1'b1}, // 20 R4 hp
    '{4'b0110,4'b0110,4'b0110,1'b1,1'b1,1'b0,1'b0,2'd2,2'd1,1'b0,1'b1}, // 21 R4 tie
    '{4'b0000,4'b0000,4'b0000,1'b1,1'b1,1'b0,1'b0,2'd2,2'd0,1'b1,1'b0}, // 22 R9
    '{4'b0110,4'b0110,4'b0110,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b0,1'b1}, // 23 R2 tie
    '{4'b1001,4'b1001,4'b0000,1'b1,1'b1,1'b0,1'b0,2'd3,2'd1,1'b0,1'b1}  // 24 R3
  };

  function automatic string tag_of(int i);
    case (i)
      0, 2, 14: return "R8";
      1, 3, 23: return "R2";
      4, 24:    return "R3";
      5, 22:    return "R9";
      6, 7, 8:  return "R6";
      9, 10, 11, 13: return "R7";
      12:       return "R5";
      default:  return "R4";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req = '0, hi_pri = '0, hi_pri_en = '0;
  logic [11:0] pri_lvl = {3'd1, 3'd5, 3'd5, 3'd2};
  logic rr_mode = 1'b0, slv_hready = 1'b1, own_lock = 1'b0, own_burst = 1'b0;
  logic [1:0] owner, arb_state;
  logic force_idle, force_nseq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_slave_arb dut (
    .clk(clk), .rst_n(rst_n), .req(req), .hi_pri(hi_pri), .hi_pri_en(hi_pri_en),
    .pri_lvl(pri_lvl), .rr_mode(rr_mode), .slv_hready(slv_hready),
    .own_lock(own_lock), .own_burst(own_burst), .owner(owner),
    .arb_state(arb_state), .force_idle(force_idle), .force_nseq(force_nseq)
  );

  task automatic chk(string what, string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(string tag, int eo, int es, int efi, int efn);
    chk("owner", tag, owner, eo);
    chk("state", tag, arb_state, es);
    chk("force_idle", tag, force_idle, efi);
    chk("force_nseq", tag, force_nseq, efn);
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (3) step();
    // R1: values under reset
    chk_all("R1", 0, 0, 1, 0);
    rst_n = 1'b1;
    step();
    chk_all("R1", 0, 0, 1, 0);

    for (int i = 0; i < NROW; i++) begin
      req = TBL[i].rq; hi_pri = TBL[i].hp; hi_pri_en = TBL[i].en;
      rr_mode = TBL[i].rr; slv_hready = TBL[i].rdy;
      own_lock = TBL[i].lk; own_burst = TBL[i].bu;
      step();
      chk_all(tag_of(i), TBL[i].own, TBL[i].st, TBL[i].fi, TBL[i].fn);
    end

    // R10: owner 3 in transition drops its request mid-cycle
    req = 4'b0000;
    #1;
    chk_all("R10", 3, 1, 1, 0);

    // R6: latched target survives a change of requests while waiting
    rr_mode = 1'b0; hi_pri = '0; hi_pri_en = '0;
    step(); // steady on 3, parked
    req = 4'b0001; slv_hready = 1'b0;
    step();
    chk_all("R6", 3, 2, 1, 0);
    req = 4'b0100;
    step();
    chk_all("R6", 3, 2, 1, 0);
    slv_hready = 1'b1;
    step();
    // R10: granted master 0 no longer requests
    chk_all("R6", 0, 1, 1, 0);

    // R1: reset in the middle of operation
    req = 4'b0010;
    step();
    chk_all("R5", 1, 1, 0, 1);
    rst_n = 1'b0;
    req = 4'b0000;
    #1;
    chk_all("R1", 0, 0, 1, 0);
    rst_n = 1'b1;
    step();
    chk_all("R1", 0, 0, 1, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule